// File: doc/BRIEF.md
# Random-Walk State Breach Tester

This controller checks whether a target state machine can be walked into a state that its specification keeps out of reach. A campaign runs a fixed number of independent attempts. Each attempt picks a starting state at random from a caller-supplied set of allowed start states and forces it into the target through a load port. It then applies random input symbols to the target, one per clock, and watches the target's state register. The attempt stops as soon as the observed state equals the protected state. If that never happens, it stops after a bounded number of symbols.

The controller reports four results per campaign: the number of breaching attempts, the sum of the walk lengths of those attempts, and the shortest and longest breaching walk. Software forms the breach rate as count over attempts and the average walk as sum over count. All randomness comes from one 32-bit linear feedback shift register, seeded at campaign start. The same seed therefore always replays the same campaign against the same target.

Top module: `walk_breach_tester`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `load_en` and `sym_valid` are low, the breach count and length sum are zero, the maximum length is zero and the minimum length is all ones.
- R2: A `start` pulse while idle begins a campaign. It clears the results and loads the generator with `seed`; a zero seed is replaced by the value 1. A `start` while busy has no effect on the campaign or its results.
- R3: Each attempt begins with exactly one cycle of `load_en`, and `load_state` is always a state whose bit is set in `start_mask`. The candidate is the low `STATE_W` bits of the generator; a candidate outside the mask is discarded and the next one drawn. A campaign performs exactly `ATTEMPTS` loads.
- R4: After a load, the block drives one symbol per cycle with `sym_valid` high. It applies at most `MAX_STEPS` symbols per attempt and never asserts `sym_valid` and `load_en` together.
- R5: When `obs_state` equals `target_state` after at least one symbol of the attempt, the attempt is a breach. No further symbol is applied in it, and its walk length is the number of symbols applied.
- R6: Only breaching attempts change the statistics: the count rises by one, the walk length adds to the sum, and the minimum and maximum track the shortest and longest breaching walk.
- R7: `done` is high for exactly one cycle after the last attempt. The results then hold their values until the next accepted start.
- R8: With an all-zero `start_mask`, the campaign ends at once with `done`, makes no loads, and leaves the results at their cleared values.
- R9: The generator is a right-shifting Galois register with feedback mask 0x80200003 (polynomial x^32+x^22+x^2+x+1). Two campaigns with the same seed, mask and target give identical results.
- R10: A breach observed right after the `MAX_STEPS`-th symbol counts, with length `MAX_STEPS`. A state first reachable only on a later symbol is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a campaign when idle |
| seed | input | 32 | Generator seed taken at start |
| start_mask | input | 2**STATE_W | One bit per allowed start state |
| target_state | input | STATE_W | Protected state to look for |
| obs_state | input | STATE_W | Current state of the target machine |
| load_en | output | 1 | Force `load_state` into the target this cycle |
| load_state | output | STATE_W | Start state to force |
| sym_valid | output | 1 | Apply `sym_out` to the target this cycle |
| sym_out | output | IN_W | Random input symbol |
| busy | output | 1 | Campaign in progress (including the done cycle) |
| done | output | 1 | One-cycle end-of-campaign pulse |
| breach_count | output | $clog2(ATTEMPTS+1) | Number of breaching attempts |
| len_sum | output | $clog2(ATTEMPTS*MAX_STEPS+1) | Sum of breaching walk lengths |
| len_min | output | $clog2(MAX_STEPS+1) | Shortest breaching walk |
| len_max | output | $clog2(MAX_STEPS+1) | Longest breaching walk |

## Verification
The hardest case to reach from the ports is the walk-length boundary: a breach that appears exactly on the last allowed symbol, next to one that would need a single symbol more. The bench reaches it with a counting target machine whose next state ignores the input. That fixes every walk length through the start mask alone, so a start at `MAX_STEPS` or `MAX_STEPS+1` states below the protected state lands on either side of the limit whatever the random symbols are. For input-dependent walks, the bench runs its own model of the target on the symbols the block actually emits. From that model it rebuilds the expected count, sum, minimum and maximum.

// File: rtl/walk_breach_tester.sv
module walk_breach_tester #(
  parameter int          STATE_W   = 6,
  parameter int          IN_W      = 4,
  parameter int          ATTEMPTS  = 10000,
  parameter int          MAX_STEPS = 100,
  parameter logic [31:0] SEED_SUB  = 32'h1
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      start,
  input  logic [31:0]                               seed,
  input  logic [(1<<STATE_W)-1:0]                   start_mask,
  input  logic [STATE_W-1:0]                        target_state,
  input  logic [STATE_W-1:0]                        obs_state,
  output logic                                      load_en,
  output logic [STATE_W-1:0]                        load_state,
  output logic                                      sym_valid,
  output logic [IN_W-1:0]                           sym_out,
  output logic                                      busy,
  output logic                                      done,
  output logic [$clog2(ATTEMPTS+1)-1:0]             breach_count,
  output logic [$clog2(ATTEMPTS*MAX_STEPS+1)-1:0]   len_sum,
  output logic [$clog2(MAX_STEPS+1)-1:0]            len_min,
  output logic [$clog2(MAX_STEPS+1)-1:0]            len_max
);
  localparam int CNT_W = $clog2(ATTEMPTS+1);
  localparam int LEN_W = $clog2(MAX_STEPS+1);
  localparam int SUM_W = $clog2(ATTEMPTS*MAX_STEPS+1);
  localparam logic [31:0] TAPS = 32'h8020_0003;

  typedef enum logic [1:0] {S_IDLE, S_DRAW, S_STEP, S_DONE} st_t;

  st_t              st;
  logic [31:0]      lfsr;
  logic [LEN_W-1:0] steps;
  logic [CNT_W-1:0] attempts;

  logic [31:0] lfsr_nxt;
  logic        pick, hit, at_limit, end_att, last_att;

  assign lfsr_nxt = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? TAPS : 32'h0);
  assign pick     = (st == S_DRAW) && start_mask[lfsr[STATE_W-1:0]];
  assign hit      = (st == S_STEP) && (steps != '0) && (obs_state == target_state);
  assign at_limit = (steps == LEN_W'(MAX_STEPS));
  assign end_att  = (st == S_STEP) && (hit || at_limit);
  assign last_att = (attempts == CNT_W'(ATTEMPTS-1));

  assign load_en    = pick;
  assign load_state = lfsr[STATE_W-1:0];
  assign sym_valid  = (st == S_STEP) && !hit && !at_limit;
  assign sym_out    = lfsr[IN_W-1:0];
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      lfsr         <= SEED_SUB;
      steps        <= '0;
      attempts     <= '0;
      breach_count <= '0;
      len_sum      <= '0;
      len_min      <= '1;
      len_max      <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lfsr         <= (seed == 32'h0) ? SEED_SUB : seed;
          attempts     <= '0;
          breach_count <= '0;
          len_sum      <= '0;
          len_min      <= '1;
          len_max      <= '0;
          st           <= (start_mask == '0) ? S_DONE : S_DRAW;
        end
        S_DRAW: begin
          lfsr <= lfsr_nxt;
          if (pick) begin
            steps <= '0;
            st    <= S_STEP;
          end
        end
        S_STEP: begin
          if (!end_att) begin
            lfsr  <= lfsr_nxt;
            steps <= steps + 1'b1;
          end else begin
            if (hit) begin
              breach_count <= breach_count + 1'b1;
              len_sum      <= len_sum + SUM_W'(steps);
              if (steps < len_min) len_min <= steps;
              if (steps > len_max) len_max <= steps;
            end
            attempts <= attempts + 1'b1;
            st       <= last_att ? S_DONE : S_DRAW;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/walk_breach_tester_chk.sv
module walk_breach_tester_chk #(
  parameter int STATE_W   = 6,
  parameter int ATTEMPTS  = 10000,
  parameter int MAX_STEPS = 100
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    start,
  input logic [(1<<STATE_W)-1:0]                 start_mask,
  input logic [STATE_W-1:0]                      target_state,
  input logic [STATE_W-1:0]                      obs_state,
  input logic                                    load_en,
  input logic [STATE_W-1:0]                      load_state,
  input logic                                    sym_valid,
  input logic                                    busy,
  input logic                                    done,
  input logic [$clog2(ATTEMPTS+1)-1:0]           breach_count,
  input logic [$clog2(ATTEMPTS*MAX_STEPS+1)-1:0] len_sum,
  input logic [$clog2(MAX_STEPS+1)-1:0]          len_min,
  input logic [$clog2(MAX_STEPS+1)-1:0]          len_max
);
  AST_LOAD_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> start_mask[load_state]); // R3
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !load_en); // R3
  AST_LOAD_SYM_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && sym_valid)); // R4
  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(sym_valid) && obs_state == target_state) |-> !sym_valid); // R5
  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len_max <= ($clog2(MAX_STEPS+1))'(MAX_STEPS)); // R6
  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (breach_count != '0) |-> (len_min <= len_max && len_min != '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(breach_count) && $stable(len_sum)
                           && $stable(len_min) && $stable(len_max))); // R7
endmodule

bind walk_breach_tester walk_breach_tester_chk #(
  .STATE_W(STATE_W), .ATTEMPTS(ATTEMPTS), .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_mask(start_mask),
  .target_state(target_state), .obs_state(obs_state), .load_en(load_en),
  .load_state(load_state), .sym_valid(sym_valid), .busy(busy), .done(done),
  .breach_count(breach_count), .len_sum(len_sum), .len_min(len_min),
  .len_max(len_max)
);

// File: tb/walk_breach_tester_tb.sv
module walk_breach_tester_tb;
  localparam int SW = 4, IW = 2, A = 20, M = 6;
  localparam int CW = $clog2(A+1), LW = $clog2(M+1), UW = $clog2(A*M+1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] seed = 32'h1;
  logic [(1<<SW)-1:0] mask = '0;
  logic [SW-1:0] prot = '0, tstate;
  logic load_en, sym_valid, busy, done;
  logic [SW-1:0] load_state;
  logic [IW-1:0] sym_out;
  logic [CW-1:0] bc;
  logic [UW-1:0] lsum;
  logic [LW-1:0] lmin, lmax;

  always #5 clk = ~clk;

  walk_breach_tester #(.STATE_W(SW), .IN_W(IW), .ATTEMPTS(A), .MAX_STEPS(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .start_mask(mask),
    .target_state(prot), .obs_state(tstate), .load_en(load_en),
    .load_state(load_state), .sym_valid(sym_valid), .sym_out(sym_out),
    .busy(busy), .done(done), .breach_count(bc), .len_sum(lsum),
    .len_min(lmin), .len_max(lmax));

  int mode = 0;
  function automatic logic [SW-1:0] fnext(int md, logic [SW-1:0] s, logic [IW-1:0] y);
    if (md == 0) return s + 1'b1;
    if (md == 1) return (y == '1) ? s + 1'b1 : s;
    return s;
  endfunction

  always_ff @(posedge clk)
    if (load_en) tstate <= load_state;
    else if (sym_valid) tstate <= fnext(mode, tstate, sym_out);

  int errors = 0, checks = 0;
  int loads, mask_bad, after_hit, over, early, r_bc, r_sum, r_min, r_max, cur, in_att, hitf;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (load_en || done) begin
      if (in_att && !hitf && cur != M) early++;
      in_att = 0;
    end
    if (load_en) begin
      loads++; if (!mask[load_state]) mask_bad++;
      cur = 0; hitf = 0; in_att = 1;
    end
    if (sym_valid) begin
      if (hitf) after_hit++;
      cur++; if (cur > M) over++;
      if (fnext(mode, tstate, sym_out) == prot) begin
        hitf = 1; r_bc++; r_sum += cur;
        if (cur < r_min) r_min = cur;
        if (cur > r_max) r_max = cur;
      end
    end
  end

  task automatic run(input logic [31:0] sd, input logic [(1<<SW)-1:0] mk,
                     input int md, input logic [SW-1:0] p, input bit extra);
    int n;
    @(negedge clk);
    seed = sd; mask = mk; mode = md; prot = p;
    loads = 0; mask_bad = 0; after_hit = 0; over = 0; early = 0;
    r_bc = 0; r_sum = 0; r_min = (1 << LW) - 1; r_max = 0; cur = 0; in_att = 0; hitf = 0;
    start = 1; @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      start = extra && (n == 10);
    end
    start = 0;
    chk(done, "R7 done reached", done, 1);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    chk(mask_bad == 0, "R3 load outside mask", mask_bad, 0);
    chk(after_hit == 0, "R5 symbol after breach", after_hit, 0);
    chk(over == 0 && early == 0, "R4 walk length bound", over + early, 0);
    chk(bc == r_bc, "R5 breach count", bc, r_bc);
    chk(lsum == r_sum, "R6 length sum", lsum, r_sum);
    chk(lmin == r_min, "R6 min length", lmin, r_min);
    chk(lmax == r_max, "R6 max length", lmax, r_max);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CW-1:0] s_bc; logic [UW-1:0] s_sum; logic [LW-1:0] s_min, s_max;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !load_en && !sym_valid, "R1 idle outputs", busy, 0);
    chk(bc == 0 && lsum == 0 && lmax == 0, "R1 cleared stats", lsum, 0);
    chk(lmin == '1, "R1 min all ones", lmin, (1 << LW) - 1);

    // R3 R5 R6: every walk breaches in three symbols
    run(32'h1234_5678, 16'h0020, 0, 4'd8, 0);
    chk(loads == A, "R3 attempts per campaign", loads, A);
    chk(bc == A && lsum == 3*A && lmin == 3 && lmax == 3, "R6 fixed length 3", lsum, 3*A);

    // R10: breach on the last allowed symbol
    run(32'hCAFE_0001, 16'h0004, 0, 4'd8, 0);
    chk(bc == A && lsum == M*A && lmin == M && lmax == M, "R10 breach at limit", lsum, M*A);

    // R10: one state further, never reported
    run(32'hCAFE_0002, 16'h0002, 0, 4'd8, 0);
    chk(bc == 0 && lsum == 0 && lmax == 0 && lmin == '1, "R10 beyond limit", bc, 0);

    // R6: self loop never breaches, wide mask
    run(32'h0BAD_F00D, 16'hFEFF, 2, 4'd8, 0);
    chk(bc == 0 && loads == A, "R6 no breach no update", bc, 0);

    // R3 R6: two start states with lengths one and two
    run(32'h5555_AAAA, 16'h00C0, 0, 4'd8, 0);
    chk(bc == A && lmin >= 1 && lmax <= 2 && lsum >= A && lsum <= 2*A, "R3 mixed starts", lsum, A);

    // R5 R6: input-dependent walks
    run(32'h00C0_FFEE, 16'h0003, 1, 4'd2, 0);
    s_bc = bc; s_sum = lsum; s_min = lmin; s_max = lmax;
    // R7 results held while idle
    repeat (7) @(negedge clk);
    chk(bc == s_bc && lsum == s_sum && lmin == s_min && lmax == s_max, "R7 results held", lsum, s_sum);

    // R2 R9: same seed with a start while busy gives identical results
    run(32'h00C0_FFEE, 16'h0003, 1, 4'd2, 1);
    chk(loads == A, "R2 start while busy ignored", loads, A);
    chk(bc == s_bc && lsum == s_sum && lmin == s_min && lmax == s_max, "R9 replay identical", lsum, s_sum);

    // R2 R9: zero seed behaves as seed one
    run(32'h1, 16'h0003, 1, 4'd2, 0);
    s_bc = bc; s_sum = lsum; s_min = lmin; s_max = lmax;
    run(32'h0, 16'h0003, 1, 4'd2, 0);
    chk(bc == s_bc && lsum == s_sum && lmin == s_min && lmax == s_max, "R2 zero seed substitute", lsum, s_sum);

    // R8 empty mask
    run(32'h77, 16'h0000, 0, 4'd8, 0);
    chk(loads == 0, "R8 no loads", loads, 0);
    chk(bc == 0 && lsum == 0 && lmax == 0 && lmin == '1, "R8 cleared results", bc, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule